// File: doc/BRIEF.md
# Seconds-Based Watchdog Timer

This block is a watchdog timer placed inside a configuration space that is reached through indexed register accesses. Three registers are reached through it: a countdown register, a control register and a trigger register. Only accesses made while the device-select match input is high reach them. The countdown register is the live timer. Writing a nonzero value arms the watchdog and loads the count. Writing zero stops the watchdog. Reading the register returns the units still remaining.

A prescaler divides the system clock into a one-second tick. When minute mode is selected, the tick comes once per sixty seconds. Each tick lowers the count by one. When the count steps from one to zero, the block latches a status flag and drives its active-low timeout output. If the control register allows it, the block also drives a low pulse of fixed length onto a keyboard-reset output.

Software keeps the watchdog alive by rewriting the countdown register. Keyboard or mouse activity strobes can also act as keep-alives when they are enabled. Keyboard activity can instead be set to stop the watchdog.

Top module: `sec_watchdog`

## Requirements
- R1: After reset the outputs and registers are in a known idle state. `wdt_to_n` and `kbrst_n` are 1. The count, control and trigger registers all read 0.
- R2: A write takes effect only in a cycle where `cfg_bank_hit` and `cfg_we` are both 1. The register addresses are: countdown 0xF6, control 0xF5, trigger 0xF7 (default map). A write of a nonzero value N to the countdown register loads N at that clock edge.
- R3: The count falls by exactly one every TICK_CLKS clocks while it is nonzero. Every load of the count restarts the prescaler, so the first decrement comes TICK_CLKS clocks after the load edge.
- R4: `cfg_rdata` is registered, with one clock of latency. It returns the selected register when `cfg_bank_hit` is 1, and 0 when `cfg_bank_hit` is 0 or the address is unmapped. A read of the countdown register returns the remaining count.
- R5: Writing 0 to the countdown register stops the watchdog. The count stays 0 and no expiry follows.
- R6: Rewriting a nonzero value while the count is running reloads the count and restarts the prescaler. Done often enough, this keeps expiry away.
- R7: When the count steps from 1 to 0 on a tick, the following happen at that same edge. The status flag (trigger register bit 4) sets and `wdt_to_n` goes to 0. The count then stays at 0. The flag and the output are cleared only by a trigger-register write with bit 4 equal to 0.
- R8: With control bit 1 set at expiry, `kbrst_n` goes low for exactly PULSE_CLKS clocks. With control bit 1 clear, `kbrst_n` stays 1.
- R9: With control bit 3 set (minute mode), one count unit lasts 60 × TICK_CLKS clocks.
- R10: Trigger bit 7 enables keyboard keep-alives and trigger bit 6 enables mouse keep-alives. An enabled activity strobe while the count is nonzero reloads the count with the last value written to the countdown register. With both bits clear, the strobes have no effect on the count.
- R11: With control bit 2 set, a keyboard strobe clears the count to 0 without an expiry.
- R12: With ALT_MAP = 1, the countdown register moves to 0xF4 and the control register to 0xF3. In that map, 0xF6 is unmapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bank_hit | input | 1 | Configuration access targets this device |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Registered read data |
| kbd_act | input | 1 | Keyboard activity strobe |
| mouse_act | input | 1 | Mouse activity strobe |
| wdt_to_n | output | 1 | Active-low timeout output |
| kbrst_n | output | 1 | Active-low keyboard-reset pulse |

## Verification
The assertions assume the following about the inputs:
- Configuration writes and activity strobes are synchronous, one-clock-wide levels sampled at the rising edge.
- TICK_CLKS is at least 2, so that two ticks never fall on adjacent cycles.
- PULSE_CLKS is at least 1.

The stimulus keeps to these limits. It drives every input on the falling edge and raises a strobe for a single cycle. It uses TICK_CLKS = 4 and PULSE_CLKS = 3, so that second-mode and minute-mode expiries both happen within a few hundred clocks.

// File: rtl/secwdt_pkg.sv
package secwdt_pkg;
  localparam int CFG_W    = 8;
  localparam int MIN_SECS = 60;

  localparam int CTL_PULSE = 1;
  localparam int CTL_KSTOP = 2;
  localparam int CTL_MIN   = 3;
  localparam int TRG_STAT  = 4;
  localparam int TRG_MOUSE = 6;
  localparam int TRG_KBD   = 7;

  localparam logic [CFG_W-1:0] TRIG_IDX = 8'hF7;

  typedef enum logic [1:0] {SEL_NONE, SEL_COUNT, SEL_CTRL, SEL_TRIG} reg_sel_e;

  function automatic reg_sel_e decode_idx(input logic [CFG_W-1:0] idx, input bit alt);
    logic [CFG_W-1:0] cnt_idx;
    logic [CFG_W-1:0] ctl_idx;
    cnt_idx = alt ? 8'hF4 : 8'hF6;
    ctl_idx = alt ? 8'hF3 : 8'hF5;
    if (idx == cnt_idx)       return SEL_COUNT;
    else if (idx == ctl_idx)  return SEL_CTRL;
    else if (idx == TRIG_IDX) return SEL_TRIG;
    else                      return SEL_NONE;
  endfunction
endpackage

// File: rtl/secwdt_regs.sv
module secwdt_regs
  import secwdt_pkg::*;
#(
  parameter bit ALT_MAP = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bank_hit,
  input  logic             we,
  input  logic [CFG_W-1:0] addr,
  input  logic [CFG_W-1:0] wdata,
  input  logic [CFG_W-1:0] count,
  input  logic             status,
  output logic             load_en,
  output logic [CFG_W-1:0] load_val,
  output logic             pulse_en,
  output logic             kbd_stop,
  output logic             minute,
  output logic             kick_kbd_en,
  output logic             kick_mouse_en,
  output logic             stat_clr,
  output logic [CFG_W-1:0] rdata
);
  reg_sel_e         sel;
  logic             wr;
  logic [CFG_W-1:0] ctrl_q;
  logic [CFG_W-1:0] trig_q;
  logic [CFG_W-1:0] rd_mux;

  always_comb sel = decode_idx(addr, ALT_MAP);
  assign wr       = bank_hit && we;
  assign load_en  = wr && (sel == SEL_COUNT);
  assign load_val = wdata;
  assign stat_clr = wr && (sel == SEL_TRIG) && !wdata[TRG_STAT];

  assign pulse_en      = ctrl_q[CTL_PULSE];
  assign kbd_stop      = ctrl_q[CTL_KSTOP];
  assign minute        = ctrl_q[CTL_MIN];
  assign kick_kbd_en   = trig_q[TRG_KBD];
  assign kick_mouse_en = trig_q[TRG_MOUSE];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      trig_q <= '0;
    end else if (wr) begin
      if (sel == SEL_CTRL) ctrl_q <= wdata;
      if (sel == SEL_TRIG) trig_q <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_COUNT: rd_mux = count;
      SEL_CTRL:  rd_mux = ctrl_q;
      SEL_TRIG: begin
        rd_mux           = trig_q;
        rd_mux[TRG_STAT] = status;
      end
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           rdata <= '0;
    else if (bank_hit) rdata <= rd_mux;
    else               rdata <= '0;
  end

  // R4: a cycle without device select yields zero read data
  p_rdata_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !bank_hit |=> rdata == '0);
endmodule

// File: rtl/secwdt_prescale.sv
module secwdt_prescale
  import secwdt_pkg::*;
#(
  parameter int unsigned TICK_CLKS = 33_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic minute,
  output logic tick
);
  localparam int PW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
  localparam int MW = $clog2(MIN_SECS);
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_CLKS - 1);
  localparam logic [MW-1:0] MIN_LAST = MW'(MIN_SECS - 1);

  logic [PW-1:0] pre_q;
  logic [MW-1:0] min_q;
  logic          wrap;

  assign wrap = (pre_q == PRE_LAST);
  assign tick = wrap && (!minute || (min_q == MIN_LAST));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre_q <= '0;
      min_q <= '0;
    end else if (wrap) begin
      pre_q <= '0;
      min_q <= (min_q == MIN_LAST) ? '0 : min_q + MW'(1);
    end else begin
      pre_q <= pre_q + PW'(1);
    end
  end

  generate
    if (TICK_CLKS > 1) begin : g_gap
      // R3: ticks never arrive on back-to-back cycles
      p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/secwdt_counter.sv
module secwdt_counter
  import secwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [CFG_W-1:0] load_val,
  input  logic             kbd_act,
  input  logic             mouse_act,
  input  logic             kick_kbd_en,
  input  logic             kick_mouse_en,
  input  logic             kbd_stop,
  input  logic             tick,
  output logic [CFG_W-1:0] count,
  output logic             restart,
  output logic             expire
);
  logic [CFG_W-1:0] cnt_q;
  logic [CFG_W-1:0] cnt_d;
  logic [CFG_W-1:0] reload_q;
  logic             kick;
  logic             running;

  assign running = (cnt_q != '0);
  assign kick    = running && ((kick_kbd_en && kbd_act) || (kick_mouse_en && mouse_act));

  always_comb begin
    cnt_d   = cnt_q;
    restart = 1'b0;
    expire  = 1'b0;
    if (load_en) begin
      cnt_d   = load_val;
      restart = 1'b1;
    end else if (kbd_stop && kbd_act) begin
      cnt_d   = '0;
      restart = 1'b1;
    end else if (kick) begin
      cnt_d   = reload_q;
      restart = 1'b1;
    end else if (tick && running) begin
      cnt_d  = cnt_q - CFG_W'(1);
      expire = (cnt_q == CFG_W'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (load_en) reload_q <= load_val;
    end
  end

  assign count = cnt_q;

  // R3: without a load or activity the count never rises
  p_no_rise_r3: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !kbd_act && !mouse_act) |=> cnt_q <= $past(cnt_q));
  // R5: a stopped count stays stopped until the next write
  p_hold_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !load_en) |=> cnt_q == '0);
endmodule

// File: rtl/secwdt_alarm.sv
module secwdt_alarm #(
  parameter int unsigned PULSE_CLKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic pulse_en,
  input  logic stat_clr,
  output logic status,
  output logic wdt_to_n,
  output logic kbrst_n
);
  localparam int QW = (PULSE_CLKS > 1) ? $clog2(PULSE_CLKS) : 1;

  logic [QW-1:0] pul_q;
  logic          kb_n_q;
  logic          stat_q;

  always_ff @(posedge clk) begin
    if (rst)           stat_q <= 1'b0;
    else if (expire)   stat_q <= 1'b1;
    else if (stat_clr) stat_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pul_q  <= '0;
      kb_n_q <= 1'b1;
    end else if (expire && pulse_en) begin
      pul_q  <= QW'(PULSE_CLKS - 1);
      kb_n_q <= 1'b0;
    end else if (pul_q != '0) begin
      pul_q  <= pul_q - QW'(1);
    end else begin
      kb_n_q <= 1'b1;
    end
  end

  assign status   = stat_q;
  assign wdt_to_n = ~stat_q;
  assign kbrst_n  = kb_n_q;

  // R7: expiry drives the timeout output low at once
  p_alarm_r7: assert property (@(posedge clk) disable iff (rst)
    expire |=> !wdt_to_n);
  // R8: the reset pulse only starts from an enabled expiry
  p_pulse_src_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(kbrst_n) |-> $past(expire && pulse_en));
endmodule

// File: rtl/sec_watchdog.sv
module sec_watchdog
  import secwdt_pkg::*;
#(
  parameter int unsigned TICK_CLKS  = 33_000_000,
  parameter int unsigned PULSE_CLKS = 16,
  parameter bit          ALT_MAP    = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_bank_hit,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             kbd_act,
  input  logic             mouse_act,
  output logic             wdt_to_n,
  output logic             kbrst_n
);
  logic             load_en;
  logic [CFG_W-1:0] load_val;
  logic             pulse_en;
  logic             kbd_stop;
  logic             minute;
  logic             kick_kbd_en;
  logic             kick_mouse_en;
  logic             stat_clr;
  logic [CFG_W-1:0] count;
  logic             status;
  logic             restart;
  logic             expire;
  logic             tick;

  secwdt_regs #(.ALT_MAP(ALT_MAP)) u_regs (
    .clk(clk), .rst(rst), .bank_hit(cfg_bank_hit), .we(cfg_we),
    .addr(cfg_addr), .wdata(cfg_wdata), .count(count), .status(status),
    .load_en(load_en), .load_val(load_val), .pulse_en(pulse_en),
    .kbd_stop(kbd_stop), .minute(minute), .kick_kbd_en(kick_kbd_en),
    .kick_mouse_en(kick_mouse_en), .stat_clr(stat_clr), .rdata(cfg_rdata)
  );

  secwdt_prescale #(.TICK_CLKS(TICK_CLKS)) u_pre (
    .clk(clk), .rst(rst), .restart(restart), .minute(minute), .tick(tick)
  );

  secwdt_counter u_cnt (
    .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_val),
    .kbd_act(kbd_act), .mouse_act(mouse_act), .kick_kbd_en(kick_kbd_en),
    .kick_mouse_en(kick_mouse_en), .kbd_stop(kbd_stop), .tick(tick),
    .count(count), .restart(restart), .expire(expire)
  );

  secwdt_alarm #(.PULSE_CLKS(PULSE_CLKS)) u_alarm (
    .clk(clk), .rst(rst), .expire(expire), .pulse_en(pulse_en),
    .stat_clr(stat_clr), .status(status), .wdt_to_n(wdt_to_n), .kbrst_n(kbrst_n)
  );
endmodule

// File: tb/sec_watchdog_test.sv
module sec_watchdog_test;
  localparam int CLK_PERIOD = 10;
  localparam int T = 4;
  localparam int P = 3;
  localparam int MAXC = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bank = 1'b0, we = 1'b0, kbd = 1'b0, mouse = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata, alt_rdata;
  logic to_n, kb_n, alt_to_n, alt_kb_n;

  int checks = 0, errors = 0, kb_low = 0;
  bit cmp_on = 0;

  // reference model state
  int m_cnt, m_ld, m_ctrl, m_trig, m_stat, m_pre, m_min, m_pul, m_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_watchdog #(.TICK_CLKS(T), .PULSE_CLKS(P), .ALT_MAP(1'b0)) uut (
    .clk(clk), .rst(rst), .cfg_bank_hit(bank), .cfg_we(we), .cfg_addr(addr),
    .cfg_wdata(wdata), .cfg_rdata(rdata), .kbd_act(kbd), .mouse_act(mouse),
    .wdt_to_n(to_n), .kbrst_n(kb_n));

  sec_watchdog #(.TICK_CLKS(T), .PULSE_CLKS(P), .ALT_MAP(1'b1)) uut_alt (
    .clk(clk), .rst(rst), .cfg_bank_hit(bank), .cfg_we(we), .cfg_addr(addr),
    .cfg_wdata(wdata), .cfg_rdata(alt_rdata), .kbd_act(kbd), .mouse_act(mouse),
    .wdt_to_n(alt_to_n), .kbrst_n(alt_kb_n));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int oc, otr;
    bit tick, hit, rs, w;
    if (rst) begin
      m_cnt = 0; m_ld = 0; m_ctrl = 0; m_trig = 0; m_stat = 0;
      m_pre = 0; m_min = 0; m_pul = 0; m_rd = 0;
    end else begin
      oc = m_ctrl; otr = m_trig;
      if (!bank) m_rd = 0;
      else if (addr == 8'hF6) m_rd = m_cnt;
      else if (addr == 8'hF5) m_rd = m_ctrl;
      else if (addr == 8'hF7) m_rd = (m_trig & 8'hEF) | (m_stat << 4);
      else m_rd = 0;
      w = bank && we;
      tick = (m_pre == T-1) && (((oc >> 3) & 1) == 0 || m_min == 59);
      hit = 0; rs = 0;
      if (w && addr == 8'hF6) begin m_cnt = wdata; m_ld = wdata; rs = 1; end
      else if (((oc >> 2) & 1) && kbd) begin m_cnt = 0; rs = 1; end
      else if (m_cnt != 0 && ((((otr >> 7) & 1) && kbd) || (((otr >> 6) & 1) && mouse))) begin
        m_cnt = m_ld; rs = 1;
      end else if (tick && m_cnt != 0) begin
        m_cnt--; hit = (m_cnt == 0);
      end
      if (rs) begin m_pre = 0; m_min = 0; end
      else if (m_pre == T-1) begin m_pre = 0; m_min = (m_min == 59) ? 0 : m_min + 1; end
      else m_pre++;
      if (hit) m_stat = 1;
      else if (w && addr == 8'hF7 && !wdata[4]) m_stat = 0;
      if (hit && ((oc >> 1) & 1)) m_pul = P;
      else if (m_pul > 0) m_pul--;
      if (w && addr == 8'hF5) m_ctrl = wdata;
      if (w && addr == 8'hF7) m_trig = wdata;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(to_n === (m_stat == 0), "R7 wdt_to_n vs model", to_n, m_stat == 0);
      chk(kb_n === (m_pul == 0), "R8 kbrst_n vs model", kb_n, m_pul == 0);
      chk(rdata === 8'(m_rd), "R4 cfg_rdata vs model", rdata, m_rd);
      if (!kb_n) kb_low++;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bank = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bank = 1; we = 0; addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kbd_pulse();
    @(negedge clk); kbd = 1;
    @(negedge clk); kbd = 0;
  endtask

  task automatic mouse_pulse();
    @(negedge clk); mouse = 1;
    @(negedge clk); mouse = 0;
  endtask

  initial begin
    repeat (MAXC) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int kb0;
    idle(3);
    rst = 0;
    cmp_on = 1;
    idle(1);
    // R1 reset state
    chk(to_n === 1'b1, "R1 to_n after reset", to_n, 1);
    chk(kb_n === 1'b1, "R1 kbrst_n after reset", kb_n, 1);
    rd(8'hF6, d); chk(d === 8'h00, "R1 count after reset", d, 0);
    rd(8'hF5, d); chk(d === 8'h00, "R1 control after reset", d, 0);
    rd(8'hF7, d); chk(d === 8'h00, "R1 trigger after reset", d, 0);

    // R2 writes without select are ignored
    @(negedge clk); bank = 0; we = 1; addr = 8'hF6; wdata = 8'h09;
    @(negedge clk); we = 0;
    // R4 no select: read data is zero
    chk(rdata === 8'h00, "R4 rdata without select", rdata, 0);
    rd(8'hF6, d); chk(d === 8'h00, "R2 unselected write ignored", d, 0);
    rd(8'h10, d); chk(d === 8'h00, "R4 unmapped read zero", d, 0);

    // R2 R7 R8 expiry with pulse
    wr(8'hF5, 8'h02);
    wr(8'hF6, 8'h03);
    rd(8'hF6, d); chk(d === 8'h03, "R2 load read back", d, 3);
    idle(T + 1);
    rd(8'hF6, d); chk(d === 8'h02 || d === 8'h01, "R3 count decremented", d, 2);
    idle(3 * T);
    chk(to_n === 1'b0, "R7 timeout asserted", to_n, 0);
    rd(8'hF6, d); chk(d === 8'h00, "R7 count held at zero", d, 0);
    rd(8'hF7, d); chk(d === 8'h10, "R7 status bit set", d, 8'h10);
    chk(kb_low == P, "R8 pulse width", kb_low, P);
    wr(8'hF7, 8'h00);
    idle(1);
    chk(to_n === 1'b1, "R7 status cleared by write", to_n, 1);

    // R5 write zero stops
    wr(8'hF6, 8'h02);
    wr(8'hF6, 8'h00);
    idle(4 * T);
    chk(to_n === 1'b1, "R5 stopped no expiry", to_n, 1);
    rd(8'hF6, d); chk(d === 8'h00, "R5 count zero", d, 0);

    // R6 keep-alive by rewrite, R8 no pulse when disabled
    wr(8'hF5, 8'h00);
    wr(8'hF6, 8'h02);
    for (int i = 0; i < 4; i++) begin idle(4); wr(8'hF6, 8'h02); end
    chk(to_n === 1'b1, "R6 rewrites keep alive", to_n, 1);
    kb0 = kb_low;
    idle(4 * T);
    chk(to_n === 1'b0, "R6 expiry after rewrites stop", to_n, 0);
    chk(kb_low == kb0, "R8 no pulse when disabled", kb_low, kb0);

    // R10 keyboard kick enabled
    wr(8'hF7, 8'h80);
    wr(8'hF6, 8'h02);
    for (int i = 0; i < 4; i++) begin idle(3); kbd_pulse(); end
    chk(to_n === 1'b1, "R10 keyboard kicks keep alive", to_n, 1);
    // R10 mouse kick enabled
    wr(8'hF7, 8'h40);
    wr(8'hF6, 8'h02);
    for (int i = 0; i < 4; i++) begin idle(3); mouse_pulse(); end
    chk(to_n === 1'b1, "R10 mouse kicks keep alive", to_n, 1);
    // R10 kicks disabled
    wr(8'hF7, 8'h00);
    wr(8'hF6, 8'h02);
    for (int i = 0; i < 3; i++) begin idle(1); kbd_pulse(); mouse_pulse(); end
    idle(2 * T);
    chk(to_n === 1'b0, "R10 disabled kicks ignored", to_n, 0);
    wr(8'hF7, 8'h00);

    // R11 keyboard stop
    wr(8'hF5, 8'h04);
    wr(8'hF6, 8'h05);
    idle(2);
    kbd_pulse();
    rd(8'hF6, d); chk(d === 8'h00, "R11 keyboard stop clears count", d, 0);
    idle(6 * T);
    chk(to_n === 1'b1, "R11 no expiry after stop", to_n, 1);

    // R9 minute mode
    wr(8'hF5, 8'h08);
    wr(8'hF6, 8'h01);
    idle(100);
    chk(to_n === 1'b1, "R9 minute unit not yet elapsed", to_n, 1);
    idle(160);
    chk(to_n === 1'b0, "R9 minute unit elapsed", to_n, 0);
    wr(8'hF7, 8'h00);

    // R12 alternate map
    wr(8'hF4, 8'h07);
    @(negedge clk); addr = 8'hF4; we = 0;
    @(negedge clk);
    chk(alt_rdata === 8'h07, "R12 alt count index", alt_rdata, 7);
    chk(rdata === 8'h00, "R12 default map ignores alt index", rdata, 0);
    wr(8'hF3, 8'h02);
    @(negedge clk); addr = 8'hF3;
    @(negedge clk);
    chk(alt_rdata === 8'h02, "R12 alt control index", alt_rdata, 2);
    @(negedge clk); addr = 8'hF6;
    @(negedge clk);
    chk(alt_rdata === 8'h00, "R12 alt map F6 unmapped", alt_rdata, 0);

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule